// File: doc/BRIEF.md
# FIFO Address Self-Test Engine with Signature Compaction

This block is a built-in self-test engine for the pointer and status logic of a cascadable FIFO memory block. A short control word is loaded serially through a test port, and a separate update strobe launches a run. One sequencer steps every depth setting from 128 up to 4096 entries. Under each setting it drives a write/read pattern chosen by a 2-bit mode code through one or more identical lanes. Each lane models the FIFO's write pointer, read pointer and occupancy, and all lanes are driven in lock-step from the same start.

Each lane keeps three 16-bit CRC compactors. The first absorbs one word per step from the write side, the second one from the read side, and the third one from the full/empty flags. When the last depth has been swept, the three signatures are copied into a per-lane result register. The result registers of all lanes form one serial chain, and test equipment shifts it out through the same port and compares it with precomputed values.

Top module: `fifo_addr_bist`

## Requirements
- R1: While busy is low, each cycle with shiftEn high shifts serIn into a 3-bit control word. After three such cycles, the first bit sent is mode bit 0, the second is mode bit 1 and the third is the start flag.
- R2: A cycle with updateEn high, busy low and the start flag set raises busy on the next cycle and latches the mode. An update with the start flag clear leaves busy low.
- R3: A run visits the depth settings D = 128, 256, 512, 1024, 2048, 4096 in ascending order, one step per cycle. A step count L(D) is spent on each setting, and one final cycle loads the result. busy therefore stays high for exactly the sum of L(D) plus one cycle.
- R4: While busy is high, updateEn and shiftEn have no effect: the run length, the result chain and serOut are all unaffected. This includes the cycle in which the signatures are loaded.
- R5: The modes, with step index s counted from 0 within each D. Mode 0: write when s<D, otherwise read, L=2D. Mode 1: write on even s, read on odd s, L=2D. Mode 2: write when s<=D, otherwise read, L=2D+2. Mode 3: write when s<D/2, read when s>=5D/2, otherwise write on even s and read on odd s, L=3D.
- R6: A write is performed only while occupancy is below D, and a read only while occupancy is above 0. A performed access advances its pointer by one modulo D. Pointers and occupancy are zero at the start of every depth setting.
- R7: Each compactor is seeded to 0xFFFF when a run starts. Each step it absorbs one 16-bit word, MSB first, through a shift-left CRC with polynomial 0x1021 (x^16+x^12+x^5+1).
- R8: The write-side word has bit 12 set when the write was performed, with the write pointer before the step in bits 11:0. The read-side word is built the same way from the read. The flag word has bit 1 = full and bit 0 = empty, both taken after the step. All other bits are zero.
- R9: From the cycle busy falls, serOut shows bit 0 of lane 0's write signature. Each cycle with shiftEn high advances the chain by one bit. Each lane gives 48 bits, LSB first, in the order write, read, flags, and lane 0 comes first. Zeros follow the last lane.
- R10: All lanes start together and, being fault-free, produce identical signatures.
- R11: After reset, busy and serOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| shiftEn | input | 1 | Serial shift strobe for control in and signatures out |
| updateEn | input | 1 | Applies the control word; starts a run if the start flag is set |
| serIn | input | 1 | Serial control data |
| serOut | output | 1 | Serial signature data |
| busy | output | 1 | High from start until the signatures are loaded |

## Verification
Two functions can fall in the same cycle: a serial shift request and the signature load in the last busy cycle. Per R4 the load wins and the shift is dropped. The bench holds shiftEn high from partway through a mode-1 run right up to the cycle busy falls, and also pulses updateEn during that run. It then requires the unchanged run length and a chain that begins with bit 0 of the write signature. That signature must match one computed in the bench from the mode sequence and the CRC definition.

// File: rtl/fifo_bist_pkg.sv
package fifo_bist_pkg;
  localparam int SIG_W = 16;
  localparam int DSEL_W = 3;
  localparam logic [SIG_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [SIG_W-1:0] CRC_SEED = 16'hFFFF;

  typedef struct packed {
    logic seed;
    logic step;
    logic wr;
    logic rd;
    logic endDepth;
    logic load;
    logic [DSEL_W-1:0] depthSel;
  } bistCtlT;

  typedef enum logic [1:0] {
    MODE_FILL_DRAIN = 2'd0,
    MODE_PINGPONG   = 2'd1,
    MODE_OVERRUN    = 2'd2,
    MODE_WRAP       = 2'd3
  } bistModeT;

  function automatic logic [SIG_W-1:0] crcAbsorb(input logic [SIG_W-1:0] cur,
                                                 input logic [SIG_W-1:0] word);
    logic [SIG_W-1:0] acc;
    logic fb;
    acc = cur;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      fb = acc[SIG_W-1] ^ word[i];
      acc = {acc[SIG_W-2:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    return acc;
  endfunction
endpackage

// File: rtl/fifo_bist_ctrl.sv
module fifo_bist_ctrl
  import fifo_bist_pkg::*;
#(
  parameter int MIN_LOG    = 7,
  parameter int NUM_DEPTHS = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    shiftEn,
  input  logic    updateEn,
  input  logic    serIn,
  output logic    busy,
  output bistCtlT ctl
);
  localparam int MAX_LOG = MIN_LOG + NUM_DEPTHS - 1;
  localparam int CNT_W   = MAX_LOG + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LOAD} stateT;

  stateT              state;
  logic [2:0]         ctlWord;
  bistModeT           mode;
  logic [DSEL_W-1:0]  depthIdx;
  logic [CNT_W-1:0]   stepCnt;
  logic [CNT_W-1:0]   depthVal;
  logic [CNT_W-1:0]   lenVal;
  logic               isWrite;
  logic               lastStep;
  logic               lastDepth;
  logic               startReq;

  always_comb begin
    depthVal = CNT_W'(1) << (MIN_LOG + int'(depthIdx));
    unique case (mode)
      MODE_FILL_DRAIN: begin
        lenVal  = depthVal << 1;
        isWrite = stepCnt < depthVal;
      end
      MODE_PINGPONG: begin
        lenVal  = depthVal << 1;
        isWrite = !stepCnt[0];
      end
      MODE_OVERRUN: begin
        lenVal  = (depthVal << 1) + CNT_W'(2);
        isWrite = stepCnt <= depthVal;
      end
      default: begin
        lenVal = (depthVal << 1) + depthVal;
        if (stepCnt < (depthVal >> 1)) isWrite = 1'b1;
        else if (stepCnt >= (depthVal << 1) + (depthVal >> 1)) isWrite = 1'b0;
        else isWrite = !stepCnt[0];
      end
    endcase
  end

  assign lastStep  = stepCnt == lenVal - CNT_W'(1);
  assign lastDepth = depthIdx == DSEL_W'(NUM_DEPTHS - 1);
  assign startReq  = (state == ST_IDLE) && updateEn && ctlWord[2];
  assign busy      = state != ST_IDLE;

  always_comb begin
    ctl.seed     = startReq;
    ctl.step     = state == ST_RUN;
    ctl.wr       = (state == ST_RUN) && isWrite;
    ctl.rd       = (state == ST_RUN) && !isWrite;
    ctl.endDepth = (state == ST_RUN) && lastStep;
    ctl.load     = state == ST_LOAD;
    ctl.depthSel = depthIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ctlWord  <= '0;
      mode     <= MODE_FILL_DRAIN;
      depthIdx <= '0;
      stepCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (shiftEn) ctlWord <= {serIn, ctlWord[2:1]};
          if (startReq) begin
            mode     <= bistModeT'(ctlWord[1:0]);
            depthIdx <= '0;
            stepCnt  <= '0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (lastStep) begin
            stepCnt <= '0;
            if (lastDepth) state <= ST_LOAD;
            else depthIdx <= depthIdx + DSEL_W'(1);
          end else begin
            stepCnt <= stepCnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_bist_lane.sv
module fifo_bist_lane
  import fifo_bist_pkg::*;
#(
  parameter int MIN_LOG    = 7,
  parameter int NUM_DEPTHS = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  bistCtlT ctl,
  input  logic    shiftGo,
  input  logic    chainIn,
  output logic    chainOut
);
  localparam int MAX_LOG = MIN_LOG + NUM_DEPTHS - 1;
  localparam int ADDR_W  = MAX_LOG;
  localparam int OCC_W   = MAX_LOG + 1;
  localparam int RES_W   = 3 * SIG_W;

  logic [ADDR_W-1:0] wrPtr, rdPtr, addrMask;
  logic [OCC_W-1:0]  occ, occNext, depthVal;
  logic [SIG_W-1:0]  wrCrc, rdCrc, flagCrc;
  logic [SIG_W-1:0]  wrWord, rdWord, flagWord;
  logic [RES_W-1:0]  resultReg;
  logic              isFull, isEmpty, wrOk, rdOk;

  always_comb begin
    depthVal = OCC_W'(1) << (MIN_LOG + int'(ctl.depthSel));
    addrMask = ADDR_W'(depthVal - OCC_W'(1));
    isFull   = occ == depthVal;
    isEmpty  = occ == '0;
    wrOk     = ctl.wr && !isFull;
    rdOk     = ctl.rd && !isEmpty;
    occNext  = occ + OCC_W'(wrOk) - OCC_W'(rdOk);
    wrWord   = SIG_W'({wrOk, wrPtr});
    rdWord   = SIG_W'({rdOk, rdPtr});
    flagWord = SIG_W'({occNext == depthVal, occNext == '0});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      occ     <= '0;
      wrCrc   <= '0;
      rdCrc   <= '0;
      flagCrc <= '0;
    end else if (ctl.seed) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      occ     <= '0;
      wrCrc   <= CRC_SEED;
      rdCrc   <= CRC_SEED;
      flagCrc <= CRC_SEED;
    end else if (ctl.step) begin
      wrCrc   <= crcAbsorb(wrCrc, wrWord);
      rdCrc   <= crcAbsorb(rdCrc, rdWord);
      flagCrc <= crcAbsorb(flagCrc, flagWord);
      if (ctl.endDepth) begin
        wrPtr <= '0;
        rdPtr <= '0;
        occ   <= '0;
      end else begin
        if (wrOk) wrPtr <= (wrPtr + ADDR_W'(1)) & addrMask;
        if (rdOk) rdPtr <= (rdPtr + ADDR_W'(1)) & addrMask;
        occ <= occNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultReg <= '0;
    else if (ctl.load) resultReg <= {flagCrc, rdCrc, wrCrc};
    else if (shiftGo) resultReg <= {chainIn, resultReg[RES_W-1:1]};
  end

  assign chainOut = resultReg[0];
endmodule

// File: rtl/fifo_addr_bist.sv
module fifo_addr_bist
  import fifo_bist_pkg::*;
#(
  parameter int NUM_LANES  = 2,
  parameter int MIN_LOG    = 7,
  parameter int NUM_DEPTHS = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic shiftEn,
  input  logic updateEn,
  input  logic serIn,
  output logic serOut,
  output logic busy
);
  bistCtlT ctl;
  logic [NUM_LANES:0] chain;
  logic shiftGo;

  fifo_bist_ctrl #(.MIN_LOG(MIN_LOG), .NUM_DEPTHS(NUM_DEPTHS)) u_ctrl (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .updateEn(updateEn),
    .serIn(serIn), .busy(busy), .ctl(ctl)
  );

  assign shiftGo = shiftEn && !busy;
  assign chain[NUM_LANES] = 1'b0;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    fifo_bist_lane #(.MIN_LOG(MIN_LOG), .NUM_DEPTHS(NUM_DEPTHS)) u_lane (
      .clk(clk), .rstN(rstN), .ctl(ctl), .shiftGo(shiftGo),
      .chainIn(chain[g+1]), .chainOut(chain[g])
    );
  end

  assign serOut = chain[0];
endmodule

// File: rtl/fifo_addr_bist_chk.sv
module fifo_addr_bist_chk (
  input logic clk,
  input logic rstN,
  input logic shiftEn,
  input logic updateEn,
  input logic serIn,
  input logic serOut,
  input logic busy
);
  logic [2:0] shadowWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowWord <= '0;
    else if (shiftEn && !busy) shadowWord <= {serIn, shadowWord[2:1]};
  end

  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && updateEn && shadowWord[2]) |=> busy);

  a_r2_idle_without_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(updateEn && shadowWord[2])) |=> !busy);

  a_r4_out_frozen_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> $stable(serOut));

  a_r3_run_spans_cycles: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  always_comb begin
    if (rstN === 1'b0) begin
      a_r11_reset_idle: assert (busy == 1'b0);
    end
  end
endmodule

bind fifo_addr_bist fifo_addr_bist_chk u_chk (.*);

// File: tb/fifo_addr_bist_tb.sv
module fifo_addr_bist_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftEn = 1'b0;
  logic updateEn = 1'b0;
  logic serIn = 1'b0;
  logic serOut, busy;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit timedOut = 1'b0;

  fifo_addr_bist #(.NUM_LANES(LANES)) u_dut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .updateEn(updateEn),
    .serIn(serIn), .serOut(serOut), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !timedOut) begin
      timedOut = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic void check(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, expv);
    end
  endfunction

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    logic top;
    r = c;
    for (int b = 15; b >= 0; b--) begin
      top = r[15];
      r = r << 1;
      if (top != w[b]) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // Expected run length and signatures from R3, R5, R6, R7, R8
  task automatic expectRun(input int mode, output int runLen, output logic [47:0] sig);
    logic [15:0] sw, sr, sf;
    int dep, len, wp, rp, occ;
    bit doW, okW, okR;
    sw = 16'hFFFF; sr = 16'hFFFF; sf = 16'hFFFF;
    runLen = 1;
    for (int k = 0; k < 6; k++) begin
      dep = 128 << k;
      case (mode)
        2: len = 2*dep + 2;
        3: len = 3*dep;
        default: len = 2*dep;
      endcase
      runLen += len;
      wp = 0; rp = 0; occ = 0;
      for (int s = 0; s < len; s++) begin
        case (mode)
          0: doW = s < dep;
          1: doW = (s % 2) == 0;
          2: doW = s <= dep;
          default: doW = (s < dep/2) ? 1'b1 : (s >= 5*dep/2) ? 1'b0 : ((s % 2) == 0);
        endcase
        okW = doW && occ < dep;
        okR = !doW && occ > 0;
        sw = refCrc(sw, 16'(okW) << 12 | 16'(wp));
        sr = refCrc(sr, 16'(okR) << 12 | 16'(rp));
        if (okW) begin wp = (wp + 1) % dep; occ++; end
        if (okR) begin rp = (rp + 1) % dep; occ--; end
        sf = refCrc(sf, {14'd0, occ == dep, occ == 0});
      end
    end
    sig = {sf, sr, sw};
  endtask

  task automatic shiftCtl(input logic [1:0] mode, input logic start);
    logic [2:0] bits;
    bits = {start, mode};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      shiftEn = 1'b1;
      serIn = bits[i];
    end
    @(negedge clk);
    shiftEn = 1'b0;
    serIn = 1'b0;
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(serOut == 1'b0, "R11 serOut after reset", serOut, 0);
  endtask

  task automatic testNoStart();
    shiftCtl(2'd1, 1'b0);
    updateEn = 1'b1;
    @(negedge clk);
    updateEn = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 update without start flag", busy, 0);
  endtask

  // R1 R3 R5 R9 R10; with poke, R4 (shift and update during busy and at load)
  task automatic runAndCheck(input int mode, input bit poke);
    int expLen, gotLen;
    logic [47:0] expSig;
    logic [47:0] got [LANES];
    bit tailOk;
    string tag;
    expectRun(mode, expLen, expSig);
    shiftCtl(mode[1:0], 1'b1);
    updateEn = 1'b1;
    @(negedge clk);
    updateEn = 1'b0;
    gotLen = 0;
    while (busy) begin
      gotLen++;
      if (poke && gotLen == 100) updateEn = 1'b1;
      if (poke && gotLen == 101) updateEn = 1'b0;
      if (poke && gotLen >= 120) begin shiftEn = 1'b1; serIn = 1'b1; end
      @(negedge clk);
    end
    shiftEn = 1'b0;
    serIn = 1'b0;
    tag = poke ? "R4 busy length with ignored requests" : "R3 busy length";
    check(gotLen == expLen, tag, gotLen, expLen);
    for (int l = 0; l < LANES; l++) begin
      for (int i = 0; i < 48; i++) begin
        got[l][i] = serOut;
        shiftEn = 1'b1;
        @(negedge clk);
      end
    end
    tailOk = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (serOut !== 1'b0) tailOk = 1'b0;
      @(negedge clk);
    end
    shiftEn = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      check(got[l][15:0] == expSig[15:0], $sformatf("R5 R7 R8 mode %0d lane %0d write sig", mode, l), got[l][15:0], expSig[15:0]);
      check(got[l][31:16] == expSig[31:16], $sformatf("R5 R6 R8 mode %0d lane %0d read sig", mode, l), got[l][31:16], expSig[31:16]);
      check(got[l][47:32] == expSig[47:32], $sformatf("R6 R8 R9 mode %0d lane %0d flag sig", mode, l), got[l][47:32], expSig[47:32]);
    end
    check(got[0] == got[LANES-1], "R10 lanes identical", got[LANES-1], got[0]);
    check(tailOk, "R9 zeros after chain", tailOk, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoStart();
    runAndCheck(0, 1'b0);
    runAndCheck(1, 1'b1);
    runAndCheck(2, 1'b0);
    runAndCheck(3, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule